// File: doc/BRIEF.md
# VC-12 Path Overhead Inserter

This block turns a stream of C-12 container bytes into a VC-12 by placing the four low-order path overhead bytes at the head of each of the four rows of a multiframe. Every row holds `ROW_LEN` byte slots, 35 by default. Slot 0 of a row carries overhead, and the remaining slots carry container data. An upstream timing source marks each active byte slot with `slot_en` and marks the first slot of a multiframe with `mf_sync`. The container byte offered on an overhead slot is discarded.

The first overhead byte of a multiframe is the V5 byte, which the block builds itself. V5 carries a 2-bit interleaved parity over every byte emitted in the previous multiframe. It also carries a remote error flag, which is taken from a receive-side status input sampled once per multiframe. The remaining V5 fields come from configuration inputs. The other three overhead bytes are configuration values that are inserted unchanged. A test control inverts the parity field of every V5 byte, so that a degraded path can be presented to a far-end receiver.

Top module: `vc12_poh_inserter`

## Requirements
- R1: A multiframe has 4 rows of `ROW_LEN` slots. The slot position advances only on cycles with `slot_en`=1 and wraps to slot 0 after the last slot of row 4. `vc_poh` is 1 exactly for outputs produced from slot 0 of a row.
- R2: The output is registered. One cycle after a cycle with `slot_en`=1, `vc_valid` is 1 and `vc_byte` holds that slot's byte. One cycle after a cycle with `slot_en`=0, `vc_valid`, `vc_poh` and `vc_byte` are all 0.
- R3: On a slot whose column is not 0, `c12_byte` is passed to `vc_byte` unchanged.
- R4: Slot 0 of rows 2, 3 and 4 carries `cfg_j2`, `cfg_n2` and `cfg_k4` respectively. `c12_byte` on those slots has no effect on the output.
- R5: The V5 byte (slot 0 of row 1) has the layout {bip[1:0] at bits 7:6, rei at bit 5, `cfg_rfi` at bit 4, `cfg_label` at bits 3:1, `cfg_rdi` at bit 0}.
- R6: V5 bit 7 is the XOR of bits 7, 5, 3 and 1 of all bytes emitted since the previous V5, including that V5. V5 bit 6 is the XOR of bits 6, 4, 2 and 0 of the same bytes.
- R7: The first V5 after reset carries a parity field of 00 when `cfg_par_inv`=0.
- R8: When `cfg_par_inv`=1, both parity bits of every V5 are inverted. Parity accumulation always uses the bytes as they are emitted.
- R9: V5 bit 5 equals `rx_bip_err` as sampled on the last slot (row 4, column `ROW_LEN`-1) of the preceding multiframe, and is 0 before the first such sample. Values of `rx_bip_err` on other cycles have no effect.
- R10: While `rst` is 1, `vc_valid`, `vc_poh` and `vc_byte` are 0.
- R11: `mf_sync`=1 with `slot_en`=1 forces the current slot to be V5 at any position. The parity in that V5 covers the bytes emitted since the previous V5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | Current cycle is an active byte slot |
| mf_sync | input | 1 | Current slot is the first slot of a multiframe |
| c12_byte | input | 8 | Container byte for the current slot |
| cfg_par_inv | input | 1 | Invert the parity field of every V5 |
| cfg_label | input | 3 | Signal label field of V5 (010 = asynchronous mapping) |
| cfg_rfi | input | 1 | Remote failure bit of V5 |
| cfg_rdi | input | 1 | Remote defect bit of V5 |
| cfg_j2 | input | 8 | Overhead byte for row 2 |
| cfg_n2 | input | 8 | Overhead byte for row 3 |
| cfg_k4 | input | 8 | Overhead byte for row 4 |
| rx_bip_err | input | 1 | Receive-side parity error status |
| vc_byte | output | 8 | VC-12 output byte |
| vc_valid | output | 1 | `vc_byte` holds a slot byte |
| vc_poh | output | 1 | `vc_byte` is an overhead byte |

## Verification
Each slot's byte appears at the outputs exactly one clock after the edge on which the slot was presented. The parity of a multiframe only appears in the next V5, at least one slot after the last byte it covers. A remote error value sampled on the final slot shows up on the following V5 output. The bench drives inputs on the falling edge and updates a behavioural model at the same moment. It then compares the outputs at the next falling edge, so each expected value is checked exactly one register stage after its stimulus. Random `rx_bip_err` toggling on every cycle shows that only the final-slot sample reaches V5.

// File: rtl/vc12_poh_pkg.sv
package vc12_poh_pkg;

    localparam int ROWS     = 4;
    localparam int ROW_W    = 2;
    localparam int LABEL_W  = 3;

    typedef enum logic [ROW_W-1:0] {
        ROW_V5 = 2'd0,
        ROW_J2 = 2'd1,
        ROW_N2 = 2'd2,
        ROW_K4 = 2'd3
    } poh_row_e;

    typedef struct packed {
        logic [1:0]         bip;
        logic               rei;
        logic               rfi;
        logic [LABEL_W-1:0] label;
        logic               rdi;
    } v5_t;

    // bit 1 of the result covers byte bits 7,5,3,1; bit 0 covers 6,4,2,0
    function automatic logic [1:0] bip_fold(input logic [7:0] b);
        bip_fold[1] = b[7] ^ b[5] ^ b[3] ^ b[1];
        bip_fold[0] = b[6] ^ b[4] ^ b[2] ^ b[0];
    endfunction

endpackage

// File: rtl/vc12_slot_timer.sv
module vc12_slot_timer
    import vc12_poh_pkg::*;
#(
    parameter int ROW_LEN = 35,
    localparam int COL_W  = $clog2(ROW_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_en,
    input  logic             mf_sync,
    output logic [COL_W-1:0] cur_col,
    output poh_row_e         cur_row,
    output logic             poh_slot,
    output logic             last_slot
);

    logic [COL_W-1:0] col_q;
    poh_row_e         row_q;
    logic             row_end;

    always_comb begin
        cur_col   = mf_sync ? '0 : col_q;
        cur_row   = mf_sync ? ROW_V5 : row_q;
        row_end   = (cur_col == COL_W'(ROW_LEN - 1));
        poh_slot  = (cur_col == '0);
        last_slot = row_end && (cur_row == ROW_K4);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            row_q <= ROW_V5;
        end else if (slot_en) begin
            if (row_end) begin
                col_q <= '0;
                row_q <= poh_row_e'(cur_row + 2'd1);
            end else begin
                col_q <= cur_col + COL_W'(1);
                row_q <= cur_row;
            end
        end
    end

endmodule

// File: rtl/vc12_bip2_acc.sv
module vc12_bip2_acc
    import vc12_poh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       upd,
    input  logic       restart,
    input  logic [7:0] byte_in,
    output logic [1:0] acc_q
);

    logic [1:0] contrib;

    always_comb contrib = bip_fold(byte_in);

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (upd)
            acc_q <= restart ? contrib : (acc_q ^ contrib);
    end

endmodule

// File: rtl/vc12_poh_inserter.sv
module vc12_poh_inserter
    import vc12_poh_pkg::*;
#(
    parameter int ROW_LEN = 35
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_en,
    input  logic               mf_sync,
    input  logic [7:0]         c12_byte,
    input  logic               cfg_par_inv,
    input  logic [LABEL_W-1:0] cfg_label,
    input  logic               cfg_rfi,
    input  logic               cfg_rdi,
    input  logic [7:0]         cfg_j2,
    input  logic [7:0]         cfg_n2,
    input  logic [7:0]         cfg_k4,
    input  logic               rx_bip_err,
    output logic [7:0]         vc_byte,
    output logic               vc_valid,
    output logic               vc_poh
);

    localparam int COL_W = $clog2(ROW_LEN);

    logic [COL_W-1:0] cur_col;
    poh_row_e         cur_row;
    logic             poh_slot;
    logic             last_slot;
    logic             v5_slot;
    logic [1:0]       bip_acc;
    logic             rei_q;
    v5_t              v5_now;
    logic [7:0]       sel_byte;

    vc12_slot_timer #(.ROW_LEN(ROW_LEN)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .slot_en   (slot_en),
        .mf_sync   (mf_sync),
        .cur_col   (cur_col),
        .cur_row   (cur_row),
        .poh_slot  (poh_slot),
        .last_slot (last_slot)
    );

    vc12_bip2_acc u_bip (
        .clk     (clk),
        .rst     (rst),
        .upd     (slot_en),
        .restart (v5_slot),
        .byte_in (sel_byte),
        .acc_q   (bip_acc)
    );

    always_comb begin
        v5_slot      = poh_slot && (cur_row == ROW_V5);
        v5_now.bip   = bip_acc ^ {2{cfg_par_inv}};
        v5_now.rei   = rei_q;
        v5_now.rfi   = cfg_rfi;
        v5_now.label = cfg_label;
        v5_now.rdi   = cfg_rdi;
        sel_byte     = c12_byte;
        if (poh_slot) begin
            unique case (cur_row)
                ROW_V5:  sel_byte = v5_now;
                ROW_J2:  sel_byte = cfg_j2;
                ROW_N2:  sel_byte = cfg_n2;
                default: sel_byte = cfg_k4;
            endcase
        end
    end

    // remote error flag frozen at the last slot, used by the next V5
    always_ff @(posedge clk) begin
        if (rst)
            rei_q <= 1'b0;
        else if (slot_en && last_slot)
            rei_q <= rx_bip_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vc_valid <= 1'b0;
            vc_poh   <= 1'b0;
            vc_byte  <= '0;
        end else begin
            vc_valid <= slot_en;
            vc_poh   <= slot_en && poh_slot;
            vc_byte  <= slot_en ? sel_byte : '0;
        end
    end

endmodule

// File: rtl/vc12_poh_checker.sv
module vc12_poh_checker
    import vc12_poh_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       slot_en,
    input logic       mf_sync,
    input logic [7:0] c12_byte,
    input logic [7:0] cfg_j2,
    input logic [7:0] vc_byte,
    input logic       vc_valid,
    input logic       vc_poh,
    input poh_row_e   cur_row,
    input logic       poh_slot,
    input logic       last_slot,
    input logic       rei_q
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        slot_en |=> vc_valid);

    assert_idle_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !slot_en |=> (!vc_valid && !vc_poh && vc_byte == 8'd0));

    assert_data_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (slot_en && !poh_slot) |=> (vc_byte == $past(c12_byte) && !vc_poh));

    assert_j2_row_R4: assert property (@(posedge clk) disable iff (rst)
        (slot_en && poh_slot && cur_row == ROW_J2) |=> (vc_byte == $past(cfg_j2) && vc_poh));

    assert_rei_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(slot_en && last_slot) |=> $stable(rei_q));

    assert_sync_v5_R11: assert property (@(posedge clk) disable iff (rst)
        (slot_en && mf_sync) |=> vc_poh);

endmodule

bind vc12_poh_inserter vc12_poh_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .slot_en   (slot_en),
    .mf_sync   (mf_sync),
    .c12_byte  (c12_byte),
    .cfg_j2    (cfg_j2),
    .vc_byte   (vc_byte),
    .vc_valid  (vc_valid),
    .vc_poh    (vc_poh),
    .cur_row   (cur_row),
    .poh_slot  (poh_slot),
    .last_slot (last_slot),
    .rei_q     (rei_q)
);

// File: tb/sim_vc12_poh_inserter.sv
module sim_vc12_poh_inserter;

    localparam int CLK_PERIOD = 10;
    localparam int RL = 35;
    localparam int MF = 4 * RL;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slot_en = 1'b0, mf_sync = 1'b0;
    logic [7:0] c12_byte = '0;
    logic       cfg_par_inv = 1'b0, cfg_rfi = 1'b0, cfg_rdi = 1'b0;
    logic [2:0] cfg_label = 3'b010;
    logic [7:0] cfg_j2 = 8'h4A, cfg_n2 = 8'h93, cfg_k4 = 8'h2C;
    logic       rx_bip_err = 1'b0;
    logic [7:0] vc_byte;
    logic       vc_valid, vc_poh;

    always #(CLK_PERIOD/2) clk = ~clk;

    vc12_poh_inserter #(.ROW_LEN(RL)) u0 (
        .clk(clk), .rst(rst), .slot_en(slot_en), .mf_sync(mf_sync),
        .c12_byte(c12_byte), .cfg_par_inv(cfg_par_inv), .cfg_label(cfg_label),
        .cfg_rfi(cfg_rfi), .cfg_rdi(cfg_rdi), .cfg_j2(cfg_j2), .cfg_n2(cfg_n2),
        .cfg_k4(cfg_k4), .rx_bip_err(rx_bip_err),
        .vc_byte(vc_byte), .vc_valid(vc_valid), .vc_poh(vc_poh)
    );

    // behavioural model state
    int         pos = 0;
    logic [1:0] m_acc = 2'b00;
    logic       m_rei = 1'b0;
    bit         first_v5 = 1'b1;
    // expectations for the next comparison
    logic       e_valid = 0, e_poh = 0;
    logic [7:0] e_byte = 0;
    bit         e_is_v5 = 0, e_resync = 0;
    string      e_tag = "R2", e_bip_tag = "R6";

    int  n_cmp = 0, n_bad = 0;
    bit  done = 0;

    function automatic logic [1:0] par2(input logic [7:0] b);
        logic [1:0] p = 2'b00;
        for (int i = 1; i <= 8; i++)
            if (b[8-i]) begin
                if (i % 2 == 1) p[1] = ~p[1];
                else            p[0] = ~p[0];
            end
        return p;
    endfunction

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic check_outputs();
        cmp("R2", {7'd0, vc_valid}, {7'd0, e_valid});
        cmp(e_resync ? "R11" : "R1", {7'd0, vc_poh}, {7'd0, e_poh});
        if (e_is_v5) begin
            cmp(e_bip_tag, {6'd0, vc_byte[7:6]}, {6'd0, e_byte[7:6]});
            cmp("R9", {7'd0, vc_byte[5]}, {7'd0, e_byte[5]});
            cmp("R5", {3'd0, vc_byte[4:0]}, {3'd0, e_byte[4:0]});
        end else begin
            cmp(e_tag, vc_byte, e_byte);
        end
    endtask

    task automatic model(input bit se, input bit sy, input logic [7:0] d, input bit rx);
        int p, row, col;
        logic [7:0] b;
        logic [1:0] bip;
        e_is_v5 = 0; e_resync = 0;
        if (!se) begin
            e_valid = 0; e_poh = 0; e_byte = 0; e_tag = "R2";
            return;
        end
        p = sy ? 0 : pos;
        e_resync = sy && (pos != 0);
        row = p / RL;
        col = p % RL;
        if (col != 0) begin
            b = d; e_tag = "R3";
        end else if (row == 0) begin
            bip = m_acc ^ (cfg_par_inv ? 2'b11 : 2'b00);
            b = {bip, m_rei, cfg_rfi, cfg_label, cfg_rdi};
            e_is_v5 = 1;
            e_bip_tag = first_v5 ? "R7" : (cfg_par_inv ? "R8" : "R6");
            first_v5 = 0;
        end else begin
            b = (row == 1) ? cfg_j2 : (row == 2) ? cfg_n2 : cfg_k4;
            e_tag = "R4";
        end
        e_valid = 1; e_poh = (col == 0); e_byte = b;
        m_acc = (p == 0) ? par2(b) : (m_acc ^ par2(b));
        if (p == MF - 1) m_rei = rx;
        pos = (p == MF - 1) ? 0 : p + 1;
    endtask

    task automatic cycle(input bit se, input bit sy, input logic [7:0] d, input bit rx);
        @(negedge clk);
        check_outputs();
        slot_en = se; mf_sync = sy; c12_byte = d; rx_bip_err = rx;
        model(se, sy, d, rx);
    endtask

    // one multiframe worth of slots; fill selects data pattern, gap inserts idle cycles
    task automatic run_slots(input int n, input int fill, input bit gaps, input bit sync_first);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            bit rx;
            rx = 1'($urandom_range(0, 1));
            if (gaps && $urandom_range(0, 3) == 0)
                cycle(1'b0, 1'b0, 8'($urandom), rx);
            d = (fill == 0) ? 8'($urandom) : (fill == 1) ? 8'h00 : 8'hFF;
            cycle(1'b1, sync_first && i == 0, d, rx);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R10", {7'd0, vc_valid}, 8'd0);
        cmp("R10", {7'd0, vc_poh}, 8'd0);
        cmp("R10", vc_byte, 8'd0);
        rst = 1'b0;
        // R1 R3 R4 R5 R6 R7 R9: back-to-back slots, random data, random remote status
        run_slots(3 * MF, 0, 1'b0, 1'b1);
        // R2: idle cycles spread through two multiframes
        run_slots(2 * MF, 0, 1'b1, 1'b0);
        // R8: parity inversion with new field values and constant patterns
        cfg_par_inv = 1'b1; cfg_rfi = 1'b1; cfg_rdi = 1'b1; cfg_label = 3'b101;
        cfg_j2 = 8'h11; cfg_n2 = 8'hEE; cfg_k4 = 8'h7F;
        run_slots(MF, 1, 1'b0, 1'b0);
        run_slots(MF, 2, 1'b0, 1'b0);
        cfg_par_inv = 1'b0;
        run_slots(MF, 0, 1'b0, 1'b0);
        // R11: early resync in the middle of row 2
        run_slots(60, 0, 1'b0, 1'b0);
        run_slots(2 * MF, 0, 1'b0, 1'b1);
        // R11: resync exactly on natural boundary
        run_slots(MF, 0, 1'b1, 1'b1);
        cycle(1'b0, 1'b0, 8'h00, 1'b0);
        cycle(1'b0, 1'b0, 8'h00, 1'b0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule